// File: doc/BRIEF.md
# Power-Management Bus Command Channel

This block takes one host request at a time and turns it into a single transaction for a serial power-management bus. A request names a transaction kind (read, write or control), a bus opcode, a 4-bit slave number, a 16-bit register address, a byte length and up to eight bytes of write data. The channel first checks the request. It folds the opcode into a compact internal opcode and builds a 32-bit command word. For a write, it hands the data words to the bus side before the command. It then polls a status vector until the transaction completes or the poll budget runs out.

The serial physical layer is not part of the block. A simple responder takes its place. The responder accepts data-word loads and a command word, answers each status poll with a 4-bit vector, and presents two 32-bit read words. The host gets a one-cycle result strobe with a 3-bit result code and, after a successful read, the gathered read bytes.

Top module: `cmdch_channel`

## Requirements
- R1: For kind read (`req_kind`=0), bus opcodes 0x60..0x7F translate to internal 15, 0x20..0x2F to 13 and 0x38..0x3F to 1. Every other read opcode is invalid.
- R2: For kind write (`req_kind`=1), bus opcodes 0x40..0x5F translate to internal 14, 0x00..0x0F to 2, 0x30..0x37 to 0 and 0x80..0xFF to 16. Every other write opcode is invalid.
- R3: For kind control (`req_kind`=2), bus opcodes 0x10, 0x11, 0x12 and 0x13 translate to internal 3, 4, 5 and 6. The command word then has zero in bits 19:0, whatever the address and length are, and no data word is loaded. Every other control opcode is invalid.
- R4: A read or write command word holds the internal opcode in bits 31:27, the slave number in 23:20, the address in 19:4 and the length minus one in 2:0. Bits 26:24 and bit 3 are zero.
- R5: The request is invalid if the opcode is invalid, if `req_kind`=3, or if a read or write has a length of 0 or above 8. An invalid request is reported with code 1 and puts no load, no command and no poll on the responder side.
- R6: For a write, data word 0 carries bytes 0..3 and data word 1 carries bytes 4..7, least significant byte first (`rsp_wd_sel` 0 or 1). Bytes at or beyond the length are sent as zero. Word 1 is loaded only when the length is above 4. All loads come before the command word.
- R7: The error bits of the status (bit 1 failure, bit 2 denied, bit 3 dropped) are ignored until bit 0 (done) is set. The first poll that shows done ends the wait.
- R8: Once done is seen, the result is denied (2) if denied is set, otherwise failed (3) if failure is set, otherwise dropped (4) if dropped is set, otherwise ok (0).
- R9: Polls are issued one per clock cycle, starting the cycle after the command. After 100 polls without done, the result is timeout (5). A done on the 100th poll still counts.
- R10: After an ok read, `res_rdata` holds read word 0 as bytes 0..3 and read word 1 as bytes 4..7, with bytes at or beyond the length zeroed. After any other result it is zero.
- R11: `busy` is high from the cycle after acceptance until the result strobe. While busy, requests are ignored.
- R12: `res_valid` is high for exactly one cycle, `busy` falls in the next cycle, and `res_code` and `res_rdata` hold until the next result. An invalid request is reported one cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; taken when not busy |
| req_kind | input | 2 | 0 read, 1 write, 2 control, 3 illegal |
| req_opcode | input | 8 | Bus opcode |
| req_sid | input | 4 | Slave number |
| req_addr | input | 16 | Register address |
| req_len | input | 4 | Byte count, 1..8 |
| req_wdata | input | 64 | Write bytes, byte 0 in bits 7:0 |
| busy | output | 1 | Transaction in progress |
| res_valid | output | 1 | One-cycle result strobe |
| res_code | output | 3 | 0 ok, 1 invalid, 2 denied, 3 failed, 4 dropped, 5 timeout |
| res_rdata | output | 64 | Gathered read bytes |
| rsp_wd_we | output | 1 | Data word load strobe |
| rsp_wd_sel | output | 1 | Which data word is loaded |
| rsp_wd_word | output | 32 | Data word value |
| rsp_cmd_we | output | 1 | Command issue strobe |
| rsp_cmd_word | output | 32 | Command word |
| rsp_stat_rd | output | 1 | Status poll strobe |
| rsp_status | input | 4 | Status vector for the current poll |
| rsp_rdata0 | input | 32 | Read word 0 |
| rsp_rdata1 | input | 32 | Read word 1 |

## Verification
The bench goes after the edges of each opcode range. A range decoded off by one would turn a neighbouring opcode such as 0x30 on a read or 0x10 on a write into a bus command, or would reject 0x7F or 0xFF. It hits lengths 0, 4, 5, 8 and 9. A wrong bound would load word 1 for a four-byte write, leak bytes past the length, or issue a nine-byte request. It presents error bits without done, sets all three error bits together, and makes done appear on exactly the 100th poll. A design that read errors early, ranked them in the wrong order or counted one poll short would then report the wrong class or a false timeout. It also keeps a second request asserted during a busy transaction, which a design that does not lock out new requests would let overwrite the command.

// File: rtl/cmdch_pkg.sv
package cmdch_pkg;

  localparam int SID_W     = 4;
  localparam int ADDR_W    = 16;
  localparam int LEN_W     = 4;
  localparam int OP_W      = 8;
  localparam int IOP_W     = 5;
  localparam int BC_W      = 3;
  localparam int WORD_W    = 32;
  localparam int MAX_BYTES = 8;
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int DATA_W    = MAX_BYTES * 8;
  localparam int STAT_W    = 4;
  localparam int RES_W     = 3;

  // status vector bit positions
  localparam int ST_DONE = 0;
  localparam int ST_FAIL = 1;
  localparam int ST_DENY = 2;
  localparam int ST_DROP = 3;

  typedef enum logic [1:0] {
    K_READ  = 2'd0,
    K_WRITE = 2'd1,
    K_CTRL  = 2'd2,
    K_NONE  = 2'd3
  } kind_e;

  typedef enum logic [RES_W-1:0] {
    RES_OK      = 3'd0,
    RES_INVALID = 3'd1,
    RES_DENIED  = 3'd2,
    RES_FAILED  = 3'd3,
    RES_DROPPED = 3'd4,
    RES_TIMEOUT = 3'd5
  } res_e;

  typedef struct packed {
    logic             ok;
    logic [IOP_W-1:0] code;
  } xlate_t;

  function automatic xlate_t xlate_opcode(input logic [1:0] kind, input logic [OP_W-1:0] op);
    xlate_t x;
    x.ok   = 1'b1;
    x.code = '0;
    unique case (kind)
      K_READ: begin
        if (op >= 8'h60 && op <= 8'h7F)      x.code = 5'd15;
        else if (op >= 8'h20 && op <= 8'h2F) x.code = 5'd13;
        else if (op >= 8'h38 && op <= 8'h3F) x.code = 5'd1;
        else                                 x.ok   = 1'b0;
      end
      K_WRITE: begin
        if (op[7])                           x.code = 5'd16;
        else if (op >= 8'h40 && op <= 8'h5F) x.code = 5'd14;
        else if (op <= 8'h0F)                x.code = 5'd2;
        else if (op >= 8'h30 && op <= 8'h37) x.code = 5'd0;
        else                                 x.ok   = 1'b0;
      end
      K_CTRL: begin
        if (op >= 8'h10 && op <= 8'h13)      x.code = 5'd3 + {3'b000, op[1:0]};
        else                                 x.ok   = 1'b0;
      end
      default: x.ok = 1'b0;
    endcase
    return x;
  endfunction

endpackage

// File: rtl/cmdch_encoder.sv
module cmdch_encoder
  import cmdch_pkg::*;
(
  input  logic [1:0]        kind,
  input  logic [OP_W-1:0]   opcode,
  input  logic [SID_W-1:0]  sid,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  output logic              ok,
  output logic [WORD_W-1:0] cmd_word
);

  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_BYTES);

  xlate_t            x;
  logic              len_ok;
  logic [LEN_W-1:0]  len_m1;
  logic [BC_W-1:0]   bc;

  assign x      = xlate_opcode(kind, opcode);
  assign len_ok = (len != '0) && (len <= LEN_MAX);
  assign len_m1 = len - LEN_W'(1);
  assign bc     = len_m1[BC_W-1:0];
  assign ok     = x.ok && ((kind == K_CTRL) || len_ok);

  always_comb begin
    if (kind == K_CTRL) cmd_word = {x.code, 3'b000, sid, 20'h00000};
    else                cmd_word = {x.code, 3'b000, sid, addr, 1'b0, bc};
  end

endmodule

// File: rtl/cmdch_lane_mask.sv
module cmdch_lane_mask #(
  parameter int NBYTES = 8,
  parameter int LEN_W  = 4
) (
  input  logic [NBYTES*8-1:0] din,
  input  logic [LEN_W-1:0]    len,
  output logic [NBYTES*8-1:0] dout
);

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    assign dout[b*8 +: 8] = (len > LEN_W'(b)) ? din[b*8 +: 8] : 8'h00;
  end

endmodule

// File: rtl/cmdch_classify.sv
module cmdch_classify
  import cmdch_pkg::*;
(
  input  logic [STAT_W-1:0] status,
  output logic              done,
  output res_e              res
);

  assign done = status[ST_DONE];

  always_comb begin
    if (status[ST_DENY])      res = RES_DENIED;
    else if (status[ST_FAIL]) res = RES_FAILED;
    else if (status[ST_DROP]) res = RES_DROPPED;
    else                      res = RES_OK;
  end

endmodule

// File: rtl/cmdch_channel.sv
module cmdch_channel
  import cmdch_pkg::*;
#(
  parameter int MAX_POLLS = 100
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [1:0]           req_kind,
  input  logic [OP_W-1:0]      req_opcode,
  input  logic [SID_W-1:0]     req_sid,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [LEN_W-1:0]     req_len,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 busy,
  output logic                 res_valid,
  output logic [RES_W-1:0]     res_code,
  output logic [DATA_W-1:0]    res_rdata,
  output logic                 rsp_wd_we,
  output logic                 rsp_wd_sel,
  output logic [WORD_W-1:0]    rsp_wd_word,
  output logic                 rsp_cmd_we,
  output logic [WORD_W-1:0]    rsp_cmd_word,
  output logic                 rsp_stat_rd,
  input  logic [STAT_W-1:0]    rsp_status,
  input  logic [WORD_W-1:0]    rsp_rdata0,
  input  logic [WORD_W-1:0]    rsp_rdata1
);

  localparam int POLL_W = $clog2(MAX_POLLS + 1);
  localparam logic [POLL_W-1:0] LAST_POLL = POLL_W'(MAX_POLLS - 1);
  localparam logic [LEN_W-1:0]  ONE_WORD  = LEN_W'(WORD_BYTES);

  typedef enum logic [2:0] {
    S_IDLE, S_LOAD0, S_LOAD1, S_ISSUE, S_POLL, S_REPORT
  } state_e;

  state_e              state_q, state_d;
  logic                cap_en;
  logic [WORD_W-1:0]   cmd_q;
  logic [DATA_W-1:0]   wd_q;
  logic [LEN_W-1:0]    len_q;
  logic [1:0]          kind_q;
  logic [POLL_W-1:0]   poll_q, poll_d;
  res_e                res_q, res_d;
  logic [DATA_W-1:0]   rd_q, rd_d;

  logic                enc_ok;
  logic [WORD_W-1:0]   enc_cmd;
  logic [DATA_W-1:0]   wd_masked;
  logic [DATA_W-1:0]   rd_masked;
  logic                st_done;
  res_e                st_res;

  cmdch_encoder u_enc (
    .kind     (req_kind),
    .opcode   (req_opcode),
    .sid      (req_sid),
    .addr     (req_addr),
    .len      (req_len),
    .ok       (enc_ok),
    .cmd_word (enc_cmd)
  );

  cmdch_lane_mask #(.NBYTES(MAX_BYTES), .LEN_W(LEN_W)) u_wmask (
    .din  (req_wdata),
    .len  (req_len),
    .dout (wd_masked)
  );

  cmdch_lane_mask #(.NBYTES(MAX_BYTES), .LEN_W(LEN_W)) u_rmask (
    .din  ({rsp_rdata1, rsp_rdata0}),
    .len  (len_q),
    .dout (rd_masked)
  );

  cmdch_classify u_cls (
    .status (rsp_status),
    .done   (st_done),
    .res    (st_res)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    cap_en  = 1'b0;
    poll_d  = poll_q;
    res_d   = res_q;
    rd_d    = rd_q;
    unique case (state_q)
      S_IDLE: begin
        if (req_valid) begin
          cap_en = 1'b1;
          rd_d   = '0;
          if (!enc_ok) begin
            res_d   = RES_INVALID;
            state_d = S_REPORT;
          end else if (req_kind == K_WRITE) begin
            state_d = S_LOAD0;
          end else begin
            state_d = S_ISSUE;
          end
        end
      end
      S_LOAD0:  state_d = (len_q > ONE_WORD) ? S_LOAD1 : S_ISSUE;
      S_LOAD1:  state_d = S_ISSUE;
      S_ISSUE: begin
        poll_d  = '0;
        state_d = S_POLL;
      end
      S_POLL: begin
        if (st_done) begin
          res_d   = st_res;
          if ((kind_q == K_READ) && (st_res == RES_OK)) rd_d = rd_masked;
          state_d = S_REPORT;
        end else if (poll_q == LAST_POLL) begin
          res_d   = RES_TIMEOUT;
          state_d = S_REPORT;
        end else begin
          poll_d  = poll_q + POLL_W'(1);
        end
      end
      S_REPORT: state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      poll_q  <= '0;
      res_q   <= RES_OK;
      rd_q    <= '0;
      cmd_q   <= '0;
      wd_q    <= '0;
      len_q   <= '0;
      kind_q  <= K_READ;
    end else begin
      state_q <= state_d;
      poll_q  <= poll_d;
      res_q   <= res_d;
      rd_q    <= rd_d;
      if (cap_en) begin
        cmd_q  <= enc_cmd;
        wd_q   <= wd_masked;
        len_q  <= req_len;
        kind_q <= req_kind;
      end
    end
  end

  assign busy         = (state_q != S_IDLE);
  assign res_valid    = (state_q == S_REPORT);
  assign res_code     = res_q;
  assign res_rdata    = rd_q;
  assign rsp_wd_we    = (state_q == S_LOAD0) || (state_q == S_LOAD1);
  assign rsp_wd_sel   = (state_q == S_LOAD1);
  assign rsp_wd_word  = rsp_wd_sel ? wd_q[DATA_W-1 -: WORD_W] : wd_q[WORD_W-1:0];
  assign rsp_cmd_we   = (state_q == S_ISSUE);
  assign rsp_cmd_word = cmd_q;
  assign rsp_stat_rd  = (state_q == S_POLL);

endmodule

// File: rtl/cmdch_channel_chk.sv
module cmdch_channel_chk #(
  parameter int MAX_POLLS = 100
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       res_valid,
  input logic [2:0] res_code,
  input logic       rsp_wd_we,
  input logic       rsp_wd_sel,
  input logic       rsp_cmd_we,
  input logic       rsp_stat_rd,
  input logic [3:0] rsp_status
);

  localparam int RUN_W = $clog2(MAX_POLLS + 2);

  logic [RUN_W-1:0] poll_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           poll_run <= '0;
    else if (rsp_stat_rd) poll_run <= poll_run + RUN_W'(1);
    else                  poll_run <= '0;
  end

  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_wd_we, rsp_cmd_we, rsp_stat_rd, res_valid})); // R12

  AST_LOAD_BEFORE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_wd_we |=> (rsp_wd_we || rsp_cmd_we)); // R6

  AST_WORD1_AFTER_WORD0: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_wd_we && rsp_wd_sel) |-> $past(rsp_wd_we && !rsp_wd_sel)); // R6

  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    poll_run <= RUN_W'(MAX_POLLS)); // R9

  AST_DONE_ENDS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_stat_rd && rsp_status[0]) |=> res_valid); // R7

  AST_RESULT_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !busy); // R12

  AST_ISSUE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_cmd_we || rsp_wd_we || rsp_stat_rd) |-> busy); // R11

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ($stable(res_code) || res_valid)); // R12

endmodule

bind cmdch_channel cmdch_channel_chk #(.MAX_POLLS(MAX_POLLS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .res_valid   (res_valid),
  .res_code    (res_code),
  .rsp_wd_we   (rsp_wd_we),
  .rsp_wd_sel  (rsp_wd_sel),
  .rsp_cmd_we  (rsp_cmd_we),
  .rsp_stat_rd (rsp_stat_rd),
  .rsp_status  (rsp_status)
);

// File: tb/cmdch_channel_bench.sv
`timescale 1ns/1ps
module cmdch_channel_bench;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_kind;
  logic [7:0]  req_opcode;
  logic [3:0]  req_sid;
  logic [15:0] req_addr;
  logic [3:0]  req_len;
  logic [63:0] req_wdata;
  logic        busy;
  logic        res_valid;
  logic [2:0]  res_code;
  logic [63:0] res_rdata;
  logic        rsp_wd_we;
  logic        rsp_wd_sel;
  logic [31:0] rsp_wd_word;
  logic        rsp_cmd_we;
  logic [31:0] rsp_cmd_word;
  logic        rsp_stat_rd;
  logic [3:0]  rsp_status;
  logic [31:0] rsp_rdata0;
  logic [31:0] rsp_rdata1;

  // responder settings
  logic [7:0]  r_done_after;
  logic [2:0]  r_err;    // {dropped, denied, failure}
  logic [2:0]  r_noise;
  logic [7:0]  poll_idx;

  // monitor
  logic        mon_clr;
  int          m_cmd_cnt;
  logic [31:0] m_cmd;
  int          m_wd_cnt;
  logic [31:0] m_w0;
  logic [31:0] m_w1;
  int          m_polls;
  logic        m_order_bad;

  int nchk;
  int nerr;

  cmdch_channel u_cmdch_channel (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_kind     (req_kind),
    .req_opcode   (req_opcode),
    .req_sid      (req_sid),
    .req_addr     (req_addr),
    .req_len      (req_len),
    .req_wdata    (req_wdata),
    .busy         (busy),
    .res_valid    (res_valid),
    .res_code     (res_code),
    .res_rdata    (res_rdata),
    .rsp_wd_we    (rsp_wd_we),
    .rsp_wd_sel   (rsp_wd_sel),
    .rsp_wd_word  (rsp_wd_word),
    .rsp_cmd_we   (rsp_cmd_we),
    .rsp_cmd_word (rsp_cmd_word),
    .rsp_stat_rd  (rsp_stat_rd),
    .rsp_status   (rsp_status),
    .rsp_rdata0   (rsp_rdata0),
    .rsp_rdata1   (rsp_rdata1)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  assign rsp_status = (poll_idx >= r_done_after) ? {r_err, 1'b1} : {r_noise, 1'b0};

  always @(posedge clk) begin
    if (mon_clr) begin
      m_cmd_cnt   <= 0;
      m_cmd       <= '0;
      m_wd_cnt    <= 0;
      m_w0        <= '0;
      m_w1        <= '0;
      m_polls     <= 0;
      m_order_bad <= 1'b0;
      poll_idx    <= '0;
    end else begin
      if (rsp_cmd_we) begin
        m_cmd_cnt <= m_cmd_cnt + 1;
        m_cmd     <= rsp_cmd_word;
        poll_idx  <= '0;
      end
      if (rsp_wd_we) begin
        m_wd_cnt <= m_wd_cnt + 1;
        if (m_cmd_cnt != 0) m_order_bad <= 1'b1;
        if (rsp_wd_sel) m_w1 <= rsp_wd_word;
        else            m_w0 <= rsp_wd_word;
      end
      if (rsp_stat_rd) begin
        m_polls  <= m_polls + 1;
        poll_idx <= poll_idx + 8'd1;
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: got=%h exp=%h", tag, got, exp);
    end
  endtask

  // bench model of the opcode translation: {valid, code}
  function automatic logic [5:0] b_xlate(input logic [1:0] k, input logic [7:0] op);
    if (k == 2'd0) begin
      if (op inside {[8'h60:8'h7F]}) return {1'b1, 5'd15};
      if (op inside {[8'h20:8'h2F]}) return {1'b1, 5'd13};
      if (op inside {[8'h38:8'h3F]}) return {1'b1, 5'd1};
    end else if (k == 2'd1) begin
      if (op inside {[8'h40:8'h5F]}) return {1'b1, 5'd14};
      if (op inside {[8'h00:8'h0F]}) return {1'b1, 5'd2};
      if (op inside {[8'h30:8'h37]}) return {1'b1, 5'd0};
      if (op inside {[8'h80:8'hFF]}) return {1'b1, 5'd16};
    end else if (k == 2'd2) begin
      if (op == 8'h10) return {1'b1, 5'd3};
      if (op == 8'h11) return {1'b1, 5'd4};
      if (op == 8'h12) return {1'b1, 5'd5};
      if (op == 8'h13) return {1'b1, 5'd6};
    end
    return 6'd0;
  endfunction

  function automatic logic [63:0] b_mask(input logic [63:0] d, input int len);
    logic [63:0] r = '0;
    for (int b = 0; b < 8; b++) if (b < len) r[b*8 +: 8] = d[b*8 +: 8];
    return r;
  endfunction

  task automatic run(input logic [1:0] k, input logic [7:0] op, input logic [3:0] sid,
                     input logic [15:0] addr, input logic [3:0] len, input logic [63:0] wd,
                     input logic [7:0] da, input logic [2:0] err, input logic [2:0] noise,
                     input logic [31:0] r0, input logic [31:0] r1, input bit storm);
    logic [5:0]  x;
    bit          valid;
    logic [31:0] ecmd;
    logic [2:0]  eres;
    logic [63:0] erd;
    logic [63:0] wm;
    int          epolls;
    int          ewd;
    int          n;
    x     = b_xlate(k, op);
    valid = x[5] && ((k == 2'd2) || (len >= 4'd1 && len <= 4'd8));
    if (k == 2'd2) ecmd = {x[4:0], 3'b000, sid, 20'h0};
    else           ecmd = {x[4:0], 3'b000, sid, addr, 1'b0, 3'(len - 4'd1)};
    if (!valid)          begin eres = 3'd1; epolls = 0; end
    else if (da >= 8'd100) begin eres = 3'd5; epolls = 100; end
    else begin
      epolls = int'(da) + 1;
      if (err[1])      eres = 3'd2;
      else if (err[0]) eres = 3'd3;
      else if (err[2]) eres = 3'd4;
      else             eres = 3'd0;
    end
    erd = (valid && k == 2'd0 && eres == 3'd0) ? b_mask({r1, r0}, int'(len)) : 64'd0;
    wm  = b_mask(wd, int'(len));
    ewd = (valid && k == 2'd1) ? ((len > 4'd4) ? 2 : 1) : 0;

    @(negedge clk);
    mon_clr = 1'b1;
    r_done_after = da; r_err = err; r_noise = noise; rsp_rdata0 = r0; rsp_rdata1 = r1;
    @(negedge clk);
    mon_clr    = 1'b0;
    req_valid  = 1'b1;
    req_kind   = k; req_opcode = op; req_sid = sid; req_addr = addr;
    req_len    = len; req_wdata = wd;
    @(negedge clk);
    if (storm) begin
      chk("R11 busy after accept", {63'd0, busy}, 64'd1);
      req_sid  = ~sid; req_addr = ~addr; req_opcode = 8'h41;
      @(negedge clk);
      @(negedge clk);
    end
    req_valid = 1'b0;
    n = 0;
    while (!res_valid && n < 400) begin
      @(negedge clk);
      n++;
    end
    chk("R5 R7 R8 R9 result code", {61'd0, res_code}, {61'd0, eres});
    chk("R10 read data", res_rdata, erd);
    chk("R4 R5 command count", 64'(m_cmd_cnt), valid ? 64'd1 : 64'd0);
    if (valid) chk("R1 R2 R3 R4 command word", {32'd0, m_cmd}, {32'd0, ecmd});
    chk("R3 R6 data load count", 64'(m_wd_cnt), 64'(ewd));
    if (ewd >= 1) chk("R6 data word 0", {32'd0, m_w0}, {32'd0, wm[31:0]});
    if (ewd == 2) chk("R6 data word 1", {32'd0, m_w1}, {32'd0, wm[63:32]});
    chk("R6 loads precede command", {63'd0, m_order_bad}, 64'd0);
    chk("R7 R9 poll count", 64'(m_polls), 64'(epolls));
    @(negedge clk);
    chk("R12 busy released", {62'd0, busy, res_valid}, 64'd0);
    chk("R12 result held", {61'd0, res_code}, {61'd0, eres});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL R12 watchdog: got=running exp=finished");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    nchk = 0; nerr = 0;
    seed = $urandom(32'h5EED_1234);
    rst_n = 1'b0; req_valid = 1'b0; req_kind = '0; req_opcode = '0; req_sid = '0;
    req_addr = '0; req_len = '0; req_wdata = '0; mon_clr = 1'b1;
    r_done_after = '0; r_err = '0; r_noise = '0; rsp_rdata0 = '0; rsp_rdata1 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 R12 reset state", {58'd0, busy, res_valid, rsp_cmd_we, rsp_wd_we, rsp_stat_rd, 1'b0}, 64'd0);

    // R1 read ranges and edges
    run(2'd0, 8'h60, 4'h3, 16'h1234, 4'd1, 64'd0, 8'd0, 3'd0, 3'd0, 32'hA1B2C3D4, 32'h11223344, 0);
    run(2'd0, 8'h7F, 4'hF, 16'hFFFF, 4'd8, 64'd0, 8'd2, 3'd0, 3'd0, 32'hDEADBEEF, 32'hCAFEF00D, 0);
    run(2'd0, 8'h2F, 4'h1, 16'h0001, 4'd5, 64'd0, 8'd1, 3'd0, 3'd0, 32'h01020304, 32'h05060708, 0);
    run(2'd0, 8'h38, 4'h2, 16'h8000, 4'd4, 64'd0, 8'd0, 3'd0, 3'd0, 32'h55AA55AA, 32'hFFFFFFFF, 0);
    run(2'd0, 8'h30, 4'h2, 16'h8000, 4'd4, 64'd0, 8'd0, 3'd0, 3'd0, 32'h1, 32'h2, 0);
    run(2'd0, 8'h80, 4'h2, 16'h8000, 4'd2, 64'd0, 8'd0, 3'd0, 3'd0, 32'h1, 32'h2, 0);
    // R2 write ranges and edges, R6 lane packing
    run(2'd1, 8'h40, 4'h4, 16'h0ABC, 4'd4, 64'h8877665544332211, 8'd0, 3'd0, 3'd0, 0, 0, 0);
    run(2'd1, 8'h0F, 4'h5, 16'h0100, 4'd5, 64'h8877665544332211, 8'd1, 3'd0, 3'd0, 0, 0, 0);
    run(2'd1, 8'h37, 4'h6, 16'h0200, 4'd8, 64'h8877665544332211, 8'd0, 3'd0, 3'd0, 0, 0, 0);
    run(2'd1, 8'h80, 4'h7, 16'h0300, 4'd1, 64'hFFFFFFFFFFFFFFFF, 8'd0, 3'd0, 3'd0, 0, 0, 0);
    run(2'd1, 8'hFF, 4'h7, 16'h0300, 4'd3, 64'hFFFFFFFFFFFFFFFF, 8'd0, 3'd0, 3'd0, 0, 0, 0);
    run(2'd1, 8'h10, 4'h7, 16'h0300, 4'd3, 64'h1, 8'd0, 3'd0, 3'd0, 0, 0, 0);
    run(2'd1, 8'h38, 4'h7, 16'h0300, 4'd3, 64'h1, 8'd0, 3'd0, 3'd0, 0, 0, 0);
    // R5 length bounds and illegal kind
    run(2'd1, 8'h40, 4'h1, 16'h0010, 4'd9, 64'h1, 8'd0, 3'd0, 3'd0, 0, 0, 0);
    run(2'd0, 8'h60, 4'h1, 16'h0010, 4'd0, 64'h1, 8'd0, 3'd0, 3'd0, 0, 0, 0);
    run(2'd3, 8'h60, 4'h1, 16'h0010, 4'd2, 64'h1, 8'd0, 3'd0, 3'd0, 0, 0, 0);
    // R3 control commands
    for (int c = 0; c < 4; c++)
      run(2'd2, 8'h10 + 8'(c), 4'(c + 9), 16'hBEEF, 4'd0, 64'hFF, 8'd0, 3'd0, 3'd0, 0, 0, 0);
    run(2'd2, 8'h14, 4'h1, 16'h0, 4'd1, 64'h0, 8'd0, 3'd0, 3'd0, 0, 0, 0);
    run(2'd2, 8'h0F, 4'h1, 16'h0, 4'd1, 64'h0, 8'd0, 3'd0, 3'd0, 0, 0, 0);
    // R8 error priority, R10 data withheld on error
    run(2'd0, 8'h61, 4'h1, 16'h0040, 4'd8, 64'h0, 8'd1, 3'b111, 3'd0, 32'h12345678, 32'h9ABCDEF0, 0);
    run(2'd1, 8'h41, 4'h1, 16'h0040, 4'd2, 64'h77, 8'd0, 3'b101, 3'd0, 0, 0, 0);
    run(2'd0, 8'h61, 4'h1, 16'h0040, 4'd3, 64'h0, 8'd0, 3'b100, 3'd0, 32'h12345678, 0, 0);
    // R7 error bits before done are ignored
    run(2'd0, 8'h22, 4'h8, 16'h0042, 4'd6, 64'h0, 8'd4, 3'd0, 3'b111, 32'hAAAA5555, 32'h0F0F0F0F, 0);
    // R9 done on the last allowed poll, then timeout
    run(2'd1, 8'h42, 4'h8, 16'h0042, 4'd6, 64'h0123456789ABCDEF, 8'd99, 3'd0, 3'b111, 0, 0, 0);
    run(2'd0, 8'h62, 4'h8, 16'h0042, 4'd6, 64'h0, 8'd200, 3'd0, 3'b010, 32'h1, 32'h2, 0);
    // R11 request held high while busy is ignored
    run(2'd1, 8'h45, 4'hA, 16'h5A5A, 4'd8, 64'hFEDCBA9876543210, 8'd5, 3'd0, 3'd0, 0, 0, 1);

    // constrained random mix
    for (int i = 0; i < 300; i++) begin
      logic [1:0] k;
      logic [7:0] da;
      logic [2:0] er;
      k  = ($urandom_range(0, 15) == 0) ? 2'd3 : 2'($urandom_range(0, 2));
      da = ($urandom_range(0, 24) == 0) ? 8'd200 : 8'($urandom_range(0, 5));
      er = ($urandom_range(0, 2) == 0) ? 3'($urandom) : 3'd0;
      run(k, 8'($urandom), 4'($urandom), 16'($urandom), 4'($urandom_range(0, 9)),
          {$urandom, $urandom}, da, er, 3'($urandom), $urandom, $urandom, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule